// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This unit carries out unsigned multiplication and division over two implicit word operands, called A and Y here, plus one explicit source word. A caller presents an 8-bit opcode with the three words and pulses a start strobe. The unit then works for a fixed number of cycles, one bit per cycle, and signals completion with a single-cycle done pulse. During that pulse it presents the new A and Y values, per-register write enables and the flag results. The caller's register file applies these values.

Multiplication forms the full 32-bit product of A and the source. The low word goes to A and the high word goes to Y, but Y is written only when the high word is nonzero. Carry and overflow both report a nonzero high word. Division takes the double word with Y on top and A below as the dividend. It writes the floored quotient to A and the remainder to Y, and leaves all arithmetic flags alone. A zero divisor aborts the operation at once: no register is written, and the error and break outputs are raised so that the caller halts execution.

Top module: `mdu_seq`

## Requirements
- R1: Only opcode 0x17 (multiply) and opcode 0x18 (divide) are accepted. A start with any other opcode is ignored: busy_o and done_o stay low.
- R2: Multiply returns the low 16 bits of the unsigned product A*source on a_o with a_we_o high.
- R3: On multiply completion, cv_we_o is 1. carry_o and overflow_o are both 1 when the high product word is nonzero and both 0 otherwise. y_we_o equals that same condition, and y_o carries the high product word.
- R4: Divide forms the dividend as {Y,A}. It returns the low 16 bits of the floored quotient on a_o and the remainder on y_o, with a_we_o and y_we_o high and cv_we_o low. A quotient wider than 16 bits is truncated to its low 16 bits.
- R5: A divide whose source is zero raises err_o and brk_o with done_o in the cycle after the start. a_we_o, y_we_o and cv_we_o stay low.
- R6: After an accepted start, busy_o is high for exactly 16 cycles for a multiply or 32 cycles for a divide. done_o follows in the next cycle.
- R7: A start, and any operand or opcode change, presented while busy_o is high has no effect on the running operation or its result.
- R8: done_o is a one-cycle pulse that is never high together with busy_o. All write enables and flag outputs are low whenever done_o is low.
- R9: After reset, busy_o, done_o and all write enables and flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when the unit is not busy |
| opcode_i | input | 8 | Operation code: 0x17 multiply, 0x18 divide |
| a_i | input | 16 | Current A register value |
| y_i | input | 16 | Current Y register value |
| src_i | input | 16 | Source operand |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 16 | New value for A, valid with done_o |
| y_o | output | 16 | New value for Y, valid with done_o |
| a_we_o | output | 1 | Write enable for A |
| y_we_o | output | 1 | Write enable for Y |
| cv_we_o | output | 1 | Carry and overflow flags are to be updated |
| carry_o | output | 1 | New carry flag |
| overflow_o | output | 1 | New overflow flag |
| err_o | output | 1 | Division by zero error |
| brk_o | output | 1 | Break request that halts execution |

## Verification
The multiply cases are chosen to tell a product that fits in 16 bits from one that spills into the high word. The set covers a small product, the all-ones square, an exact power of two landing at bit 16, and a zero operand. Together they show whether the Y write enable and the carry/overflow pair track only the high word. The divide cases separate a plain small quotient, a quotient wider than 16 bits that must be truncated, an all-ones dividend and divisor, and a nonzero Y that only a correct {Y,A} dividend handles. A zero divisor, an unknown opcode and a second start during a run check the paths that must leave results untouched. Busy-cycle counts and done timing are measured in every case.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_MUL = 8'h17;
  localparam logic [OPC_W-1:0] OPC_DIV = 8'h18;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mdu_state_e;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int unsigned MUL_STEPS = 16,
  parameter int unsigned DIV_STEPS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic go_div_i,
  input  logic go_skip_i,
  output logic busy_o,
  output logic done_o,
  output logic step_o
);
  localparam int unsigned MAX_STEPS = (DIV_STEPS > MUL_STEPS) ? DIV_STEPS : MUL_STEPS;
  localparam int unsigned CNT_W = $clog2(MAX_STEPS + 1);
  localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(MUL_STEPS - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_STEPS - 1);

  mdu_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic is_div_q;
  logic last;

  assign last   = is_div_q ? (cnt_q == DIV_LAST) : (cnt_q == MUL_LAST);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign step_o = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      is_div_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) state_q <= ST_DONE;
        end
        default: begin
          if (go_i) begin
            cnt_q    <= '0;
            is_div_q <= go_div_i;
            state_q  <= go_skip_i ? ST_DONE : ST_RUN;
          end else begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mdu_mul_dp.sv
module mdu_mul_dp #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o
);
  localparam int unsigned SUM_W = WORD_W + 1;

  logic [WORD_W-1:0] hi_q, lo_q, mcand_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W+WORD_W-1:0] cat;

  // add multiplicand when the current multiplier bit is set, then shift right
  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
  assign cat = {sum, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      hi_q    <= '0;
      lo_q    <= a_i;
      mcand_q <= src_i;
    end else if (step_i) begin
      hi_q <= cat[SUM_W+WORD_W-1:WORD_W+1];
      lo_q <= cat[WORD_W:1];
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/mdu_div_dp.sv
module mdu_div_dp #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   y_i,
  input  logic [WORD_W-1:0]   src_i,
  output logic [2*WORD_W-1:0] quot_o,
  output logic [WORD_W-1:0]   rem_o
);
  localparam int unsigned DW = 2 * WORD_W;

  logic [DW-1:0]     num_q;
  logic [WORD_W-1:0] rem_q, dvs_q;
  logic [WORD_W:0]   part, diff;
  logic              fits;

  // restoring step: bring down next dividend bit, subtract when it fits
  assign part = {rem_q, num_q[DW-1]};
  assign diff = part - {1'b0, dvs_q};
  assign fits = (part >= {1'b0, dvs_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      num_q <= {y_i, a_i};
      rem_q <= '0;
      dvs_q <= src_i;
    end else if (step_i) begin
      num_q <= {num_q[DW-2:0], fits};
      rem_q <= fits ? diff[WORD_W-1:0] : part[WORD_W-1:0];
    end
  end

  assign quot_o = num_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] src_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] y_o,
  output logic              a_we_o,
  output logic              y_we_o,
  output logic              cv_we_o,
  output logic              carry_o,
  output logic              overflow_o,
  output logic              err_o,
  output logic              brk_o
);
  localparam int unsigned MUL_STEPS = WORD_W;
  localparam int unsigned DIV_STEPS = 2 * WORD_W;

  logic is_mul, is_div, go, skip, step;
  logic div_q, dz_q;
  logic [WORD_W-1:0]   p_hi, p_lo, rem;
  logic [2*WORD_W-1:0] quot;
  logic hi_nz;

  assign is_mul = (opcode_i == OPC_MUL);
  assign is_div = (opcode_i == OPC_DIV);
  assign go     = start_i && !busy_o && (is_mul || is_div);
  assign skip   = is_div && (src_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      dz_q  <= 1'b0;
    end else if (go) begin
      div_q <= is_div;
      dz_q  <= skip;
    end
  end

  mdu_ctrl #(.MUL_STEPS(MUL_STEPS), .DIV_STEPS(DIV_STEPS)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .go_div_i (is_div),
    .go_skip_i(skip),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .step_o   (step)
  );

  mdu_mul_dp #(.WORD_W(WORD_W)) i_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(go),
    .step_i(step && !div_q),
    .a_i   (a_i),
    .src_i (src_i),
    .hi_o  (p_hi),
    .lo_o  (p_lo)
  );

  mdu_div_dp #(.WORD_W(WORD_W)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(go),
    .step_i(step && div_q),
    .a_i   (a_i),
    .y_i   (y_i),
    .src_i (src_i),
    .quot_o(quot),
    .rem_o (rem)
  );

  assign hi_nz = (p_hi != '0);

  always_comb begin
    a_o        = '0;
    y_o        = '0;
    a_we_o     = 1'b0;
    y_we_o     = 1'b0;
    cv_we_o    = 1'b0;
    carry_o    = 1'b0;
    overflow_o = 1'b0;
    err_o      = 1'b0;
    brk_o      = 1'b0;
    if (done_o) begin
      if (!div_q) begin
        a_o        = p_lo;
        y_o        = p_hi;
        a_we_o     = 1'b1;
        y_we_o     = hi_nz;
        cv_we_o    = 1'b1;
        carry_o    = hi_nz;
        overflow_o = hi_nz;
      end else if (dz_q) begin
        err_o = 1'b1;
        brk_o = 1'b1;
      end else begin
        a_o    = quot[WORD_W-1:0];
        y_o    = rem;
        a_we_o = 1'b1;
        y_we_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdu_seq_chk.sv
module mdu_seq_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              a_we_o,
  input logic              y_we_o,
  input logic              cv_we_o,
  input logic              carry_o,
  input logic              overflow_o,
  input logic              err_o,
  input logic              brk_o
);
  // R8
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(a_we_o || y_we_o || cv_we_o || carry_o || overflow_o || err_o || brk_o));
  // R5
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (brk_o && done_o && !a_we_o && !y_we_o && !cv_we_o));
  // R3
  cv_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cv_we_o |-> ((carry_o == overflow_o) && (y_we_o == carry_o) && a_we_o));
  // R4
  div_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cv_we_o && !err_o) |-> (a_we_o && y_we_o && !carry_o && !overflow_o));
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  // R6
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind mdu_seq mdu_seq_chk #(.WORD_W(WORD_W)) i_mdu_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .a_we_o    (a_we_o),
  .y_we_o    (y_we_o),
  .cv_we_o   (cv_we_o),
  .carry_o   (carry_o),
  .overflow_o(overflow_o),
  .err_o     (err_o),
  .brk_o     (brk_o)
);

// File: tb/test_mdu_seq.sv
module test_mdu_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] a_i = '0, y_i = '0, src_i = '0;
  logic        busy_o, done_o, a_we_o, y_we_o, cv_we_o, carry_o, overflow_o, err_o, brk_o;
  logic [15:0] a_o, y_o;

  int checks = 0;
  int failures = 0;

  // values captured at the done pulse
  int          lat, busy_cnt;
  logic [15:0] c_a, c_y;
  logic        c_awe, c_ywe, c_cvwe, c_c, c_v, c_err, c_brk;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mdu_seq i_mdu_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
    .a_i(a_i), .y_i(y_i), .src_i(src_i), .busy_o(busy_o), .done_o(done_o),
    .a_o(a_o), .y_o(y_o), .a_we_o(a_we_o), .y_we_o(y_we_o), .cv_we_o(cv_we_o),
    .carry_o(carry_o), .overflow_o(overflow_o), .err_o(err_o), .brk_o(brk_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one operation; inj>0 injects a disturbing start at that cycle
  task automatic run_op(input logic [7:0] opc, input logic [15:0] a, input logic [15:0] y,
                        input logic [15:0] s, input int inj);
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = opc; a_i = a; y_i = y; src_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1; busy_cnt = 0;
    while (lat < 200) begin
      start_i = 1'b0;
      if (busy_o) busy_cnt++;
      if (done_o) break;
      if (lat == inj) begin
        start_i = 1'b1; opcode_i = 8'h18; a_i = 16'h5555; y_i = 16'h0; src_i = 16'h0;
      end
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    c_a = a_o; c_y = y_o; c_awe = a_we_o; c_ywe = y_we_o; c_cvwe = cv_we_o;
    c_c = carry_o; c_v = overflow_o; c_err = err_o; c_brk = brk_o;
    @(negedge clk_i);
    chk("R8 done one cycle", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 busy", {31'b0, busy_o}, 0);
    chk("R9 done", {31'b0, done_o}, 0);
    chk("R9 strobes", {23'b0, a_we_o, y_we_o, cv_we_o, carry_o, overflow_o, err_o, brk_o, 2'b0}, 0);
  endtask

  task automatic t_mul(input logic [15:0] a, input logic [15:0] s, input int inj);
    logic [31:0] p;
    logic nz;
    p  = {16'b0, a} * {16'b0, s};
    nz = (p[31:16] != 16'h0);
    run_op(8'h17, a, 16'hBEEF, s, inj);
    chk("R6 mul latency", lat, 17);
    chk("R6 mul busy cycles", busy_cnt, 16);
    chk("R2 mul low word", {16'b0, c_a}, {16'b0, p[15:0]});
    chk("R2 mul a_we", {31'b0, c_awe}, 1);
    chk("R3 mul cv_we", {31'b0, c_cvwe}, 1);
    chk("R3 mul carry", {31'b0, c_c}, {31'b0, nz});
    chk("R3 mul overflow", {31'b0, c_v}, {31'b0, nz});
    chk("R3 mul y_we", {31'b0, c_ywe}, {31'b0, nz});
    if (nz) chk("R3 mul high word", {16'b0, c_y}, {16'b0, p[31:16]});
    chk("R5 mul no err", {30'b0, c_err, c_brk}, 0);
  endtask

  task automatic t_div(input logic [15:0] y, input logic [15:0] a, input logic [15:0] s);
    logic [31:0] n, q, r;
    n = {y, a};
    q = n / {16'b0, s};
    r = n % {16'b0, s};
    run_op(8'h18, a, y, s, 0);
    chk("R6 div latency", lat, 33);
    chk("R6 div busy cycles", busy_cnt, 32);
    chk("R4 div quotient", {16'b0, c_a}, {16'b0, q[15:0]});
    chk("R4 div remainder", {16'b0, c_y}, r);
    chk("R4 div writes", {30'b0, c_awe, c_ywe}, 32'd3);
    chk("R4 div no flags", {29'b0, c_cvwe, c_c, c_v}, 0);
    chk("R4 div no err", {30'b0, c_err, c_brk}, 0);
  endtask

  task automatic t_div_zero();
    run_op(8'h18, 16'h1234, 16'h0042, 16'h0000, 0);
    chk("R5 dz latency", lat, 1);
    chk("R5 dz busy cycles", busy_cnt, 0);
    chk("R5 dz err", {31'b0, c_err}, 1);
    chk("R5 dz brk", {31'b0, c_brk}, 1);
    chk("R5 dz no writes", {29'b0, c_awe, c_ywe, c_cvwe}, 0);
  endtask

  task automatic t_bad_opcode(input logic [7:0] opc);
    int act;
    act = 0;
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = opc; a_i = 16'd3; src_i = 16'd4;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busy_o || done_o) act++;
      @(negedge clk_i);
    end
    chk("R1 unknown opcode ignored", act, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mul(16'd3, 16'd5, 0);
    t_mul(16'hFFFF, 16'hFFFF, 0);
    t_mul(16'h0100, 16'h0100, 0);
    t_mul(16'h1234, 16'h0000, 0);
    t_mul(16'h8001, 16'h0002, 0);
    t_div(16'h0000, 16'd100, 16'd7);
    t_div(16'h0001, 16'h0000, 16'h0001);  // quotient 0x10000 truncates
    t_div(16'hFFFF, 16'hFFFF, 16'hFFFF);
    t_div(16'h0003, 16'h0007, 16'h0010);
    t_div_zero();
    t_bad_opcode(8'h02);
    t_bad_opcode(8'h19);
    // R7: second start (divide by zero) during a multiply is ignored
    t_mul(16'd7, 16'd9, 4);
    t_mul(16'hABCD, 16'h1357, 10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule